// File: doc/BRIEF.md
# Tap Skew Calibrator

This controller removes the fixed skew between four input lanes that carry copies of one serial stream. The lanes then receive deliberate phase offsets in steps of one eighth of a bit period. Each lane passes through an external delay line of 64 taps, and an external generator repeats a known reference byte. The calibrator handles one lane at a time. It starts that lane at tap 0 and raises the tap one step at a time. At each step it waits a programmable settle time and then compares the lane's captured byte with the reference. When the capture goes bad, it records the tap where that happened.

Once every lane has a recorded tap, the block finds the smallest one and subtracts it from each lane. To the result it adds a floor of five taps, because a delay line is only trustworthy as an average over several taps. It then adds the lane's own phase offset, converted to whole taps. All lanes receive their final values in a single cycle, and a done flag is raised. A lane that never fails is reported as a timeout. A final value that does not fit in the line is clamped and reported.

Top module: `tap_skew_cal`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all tap values are 0, no load is pulsed, `busy` and `done` are 0, and both error vectors are 0.
- R2: A `start` pulse while idle raises `busy` on the next clock, clears `done` and both error vectors, and begins calibration. A `start` pulse while `busy` is high is ignored and does not change the results.
- R3: Lanes are swept in order 0 to 3. Each lane starts at tap 0 and steps by one. Every tap tried pulses exactly one `tap_load` bit, the one for the active lane, so one run has sum(recorded+1) single-lane loads.
- R4: After each tap load, no comparison is made until `settle_len` clock cycles have passed. A delay line whose output lags its setting by fewer cycles than `settle_len` still gives the true failing tap.
- R5: A tap counts as failing only after MISS_RUN (default 3) consecutive cycles in which the active lane's captured byte differs from `ref_byte`. A single matching cycle ends the test of that tap, and the sweep moves on. The recorded tap is the failing tap.
- R6: If a lane reaches tap 63 without failing, its recorded tap is 63 and its bit in `timeout_err` is set. A lane that fails exactly at tap 63 sets no timeout.
- R7: Final tap of lane c = recorded(c) - min(recorded) + 5 + off(c). Here off = 0, 5, 10, 15 taps for lanes 0..3: c times 400 ps (an eighth of a 3.2 ns bit) divided by a 78.125 ps tap, rounded to nearest.
- R8: A final value above 63 is driven as 63, and the lane's bit in `sat_err` is set.
- R9: Final values are driven with all four `tap_load` bits high for one cycle. `done` rises in that same cycle and `busy` falls. `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (pulse) |
| settle_len | input | 8 | Cycles to wait after each tap load before comparing |
| ref_byte | input | 8 | Known reference byte sent by the pattern source |
| cap_bytes | input | 32 | Captured bytes, lane c at bits [8c+7:8c] |
| tap_val | output | 24 | Tap setting, lane c at bits [6c+5:6c] |
| tap_load | output | 4 | One-cycle load strobe per lane |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Final taps applied |
| timeout_err | output | 4 | Lane never failed up to tap 63 |
| sat_err | output | 4 | Lane's final tap clamped to 63 |

## Verification
The bench models each delay line as a per-lane failing threshold, seen through a three-cycle lag. Thresholds that are spread out, all equal, or start at zero test the normalization and the offset overlay. An alternating match/mismatch band just below each threshold separates a detector that needs a full run of misses from one that trusts a single miss. The lag separates a design that honours the settle count from one that compares too early. A threshold beyond the line, a threshold exactly at tap 63, and large thresholds whose finals overflow exercise the timeout and clamp paths. A restart pulse in the middle of a run shows that `start` is ignored while `busy` is high.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_NEXT,
    ST_APPLY
  } cal_state_t;

  // Phase offset of lane idx in whole taps, rounded to nearest:
  // idx * (ui / steps) / tap
  function automatic int phase_taps(int idx, longint ui_fs, longint tap_fs, int steps);
    longint num;
    num = (2 * longint'(idx) * ui_fs) / longint'(steps) + tap_fs;
    return int'(num / (2 * tap_fs));
  endfunction

endpackage

// File: rtl/cal_miss_detect.sv
module cal_miss_detect #(
  parameter int BYTE_W   = 8,
  parameter int SETTLE_W = 8,
  parameter int MISS_RUN = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [BYTE_W-1:0]   cap,
  input  logic [BYTE_W-1:0]   ref_byte,
  output logic                vld,
  output logic                bad
);
  localparam int RUN_W = $clog2(MISS_RUN + 1);

  logic                active;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [RUN_W-1:0]    run;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      wait_cnt <= '0;
      run      <= '0;
      vld      <= 1'b0;
      bad      <= 1'b0;
    end else begin
      vld <= 1'b0;
      bad <= 1'b0;
      if (arm) begin
        active   <= 1'b1;
        wait_cnt <= settle_len;
        run      <= '0;
      end else if (active) begin
        if (wait_cnt != '0) begin
          wait_cnt <= wait_cnt - 1'b1;
        end else if (cap != ref_byte) begin
          if (run == RUN_W'(MISS_RUN - 1)) begin
            vld    <= 1'b1;
            bad    <= 1'b1;
            active <= 1'b0;
            run    <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          vld    <= 1'b1;
          active <= 1'b0;
          run    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cal_min_find.sv
module cal_min_find #(
  parameter int N = 4,
  parameter int W = 6
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   min_o
);
  always_comb begin
    min_o = vals[W-1:0];
    for (int i = 1; i < N; i++) begin
      if (vals[i*W +: W] < min_o) min_o = vals[i*W +: W];
    end
  end
endmodule

// File: rtl/cal_tap_compose.sv
module cal_tap_compose import cal_pkg::*; #(
  parameter int     N           = 4,
  parameter int     W           = 6,
  parameter int     MIN_USE     = 5,
  parameter int     PHASE_STEPS = 8,
  parameter longint UI_FS       = 3_200_000,
  parameter longint TAP_FS      = 78_125
) (
  input  logic [N*W-1:0] rec,
  input  logic [W-1:0]   min_tap,
  output logic [N*W-1:0] fin,
  output logic [N-1:0]   sat_o
);
  localparam int MAXV  = (1 << W) - 1;
  localparam int SUM_W = W + 10;

  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam int OFF = phase_taps(g, UI_FS, TAP_FS, PHASE_STEPS);
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(rec[g*W +: W]) - SUM_W'(min_tap)
               + SUM_W'(MIN_USE) + SUM_W'(OFF);
    assign sat_o[g]         = sum > SUM_W'(MAXV);
    assign fin[g*W +: W]    = sat_o[g] ? W'(MAXV) : sum[W-1:0];
  end
endmodule

// File: rtl/tap_skew_cal.sv
module tap_skew_cal import cal_pkg::*; #(
  parameter int     NUM_CH      = 4,
  parameter int     TAP_W       = 6,
  parameter int     BYTE_W      = 8,
  parameter int     SETTLE_W    = 8,
  parameter int     MISS_RUN    = 3,
  parameter int     MIN_USE     = 5,
  parameter int     PHASE_STEPS = 8,
  parameter longint UI_FS       = 3_200_000,
  parameter longint TAP_FS      = 78_125
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SETTLE_W-1:0]      settle_len,
  input  logic [BYTE_W-1:0]        ref_byte,
  input  logic [NUM_CH*BYTE_W-1:0] cap_bytes,
  output logic [NUM_CH*TAP_W-1:0]  tap_val,
  output logic [NUM_CH-1:0]        tap_load,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_CH-1:0]        timeout_err,
  output logic [NUM_CH-1:0]        sat_err
);
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  cal_state_t               st;
  logic [CH_W-1:0]          ch;
  logic [TAP_W-1:0]         cur;
  logic [TAP_W-1:0]         taps_q [NUM_CH];
  logic [TAP_W-1:0]         rec_q  [NUM_CH];
  logic [NUM_CH*TAP_W-1:0]  rec_flat;
  logic [NUM_CH*TAP_W-1:0]  fin_flat;
  logic [TAP_W-1:0]         min_tap;
  logic [NUM_CH-1:0]        sat_vec;
  logic [BYTE_W-1:0]        cap_sel;
  logic                     arm;
  logic                     det_vld;
  logic                     det_bad;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign rec_flat[g*TAP_W +: TAP_W] = rec_q[g];
    assign tap_val[g*TAP_W +: TAP_W]  = taps_q[g];
  end

  assign cap_sel = cap_bytes[ch*BYTE_W +: BYTE_W];
  assign arm     = (st == ST_LOAD);

  cal_miss_detect #(
    .BYTE_W  (BYTE_W),
    .SETTLE_W(SETTLE_W),
    .MISS_RUN(MISS_RUN)
  ) u_det (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .settle_len(settle_len),
    .cap       (cap_sel),
    .ref_byte  (ref_byte),
    .vld       (det_vld),
    .bad       (det_bad)
  );

  cal_min_find #(.N(NUM_CH), .W(TAP_W)) u_min (
    .vals (rec_flat),
    .min_o(min_tap)
  );

  cal_tap_compose #(
    .N          (NUM_CH),
    .W          (TAP_W),
    .MIN_USE    (MIN_USE),
    .PHASE_STEPS(PHASE_STEPS),
    .UI_FS      (UI_FS),
    .TAP_FS     (TAP_FS)
  ) u_comp (
    .rec    (rec_flat),
    .min_tap(min_tap),
    .fin    (fin_flat),
    .sat_o  (sat_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ch          <= '0;
      cur         <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      tap_load    <= '0;
      timeout_err <= '0;
      sat_err     <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        taps_q[i] <= '0;
        rec_q[i]  <= '0;
      end
    end else begin
      tap_load <= '0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            busy        <= 1'b1;
            done        <= 1'b0;
            timeout_err <= '0;
            sat_err     <= '0;
            ch          <= '0;
            cur         <= '0;
            st          <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          taps_q[ch]   <= cur;
          tap_load[ch] <= 1'b1;
          st           <= ST_WAIT;
        end
        ST_WAIT: begin
          if (det_vld) begin
            if (det_bad) begin
              rec_q[ch] <= cur;
              st        <= ST_NEXT;
            end else if (cur == TAP_W'(TAP_MAX)) begin
              rec_q[ch]       <= cur;
              timeout_err[ch] <= 1'b1;
              st              <= ST_NEXT;
            end else begin
              cur <= cur + 1'b1;
              st  <= ST_LOAD;
            end
          end
        end
        ST_NEXT: begin
          if (ch == CH_W'(NUM_CH - 1)) begin
            st <= ST_APPLY;
          end else begin
            ch  <= ch + 1'b1;
            cur <= '0;
            st  <= ST_LOAD;
          end
        end
        ST_APPLY: begin
          for (int i = 0; i < NUM_CH; i++) taps_q[i] <= fin_flat[i*TAP_W +: TAP_W];
          tap_load <= '1;
          sat_err  <= sat_vec;
          busy     <= 1'b0;
          done     <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tap_cal_checker.sv
module tap_cal_checker #(
  parameter int NUM_CH = 4,
  parameter int TAP_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    done,
  input logic [NUM_CH-1:0]       tap_load,
  input logic [NUM_CH*TAP_W-1:0] tap_val,
  input logic [NUM_CH-1:0]       timeout_err,
  input logic [NUM_CH-1:0]       sat_err
);
  localparam logic [TAP_W-1:0] TOP = '1;

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_apply_then_done_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(tap_load) > 1) |-> done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  assert_sweep_load_busy_R3: assert property (@(posedge clk) disable iff (rst)
    ($countones(tap_load) == 1) |-> busy);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assert_clamp_top_R8: assert property (@(posedge clk) disable iff (rst)
      (done && sat_err[g]) |-> (tap_val[g*TAP_W +: TAP_W] == TOP));

    assert_timeout_in_run_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(timeout_err[g]) |-> busy);
  end
endmodule

bind tap_skew_cal tap_cal_checker #(.NUM_CH(NUM_CH), .TAP_W(TAP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .tap_load   (tap_load),
  .tap_val    (tap_val),
  .timeout_err(timeout_err),
  .sat_err    (sat_err)
);

// File: tb/tap_skew_cal_bench.sv
`timescale 1ns/1ps
module tap_skew_cal_bench;
  localparam int N   = 4;
  localparam int TW  = 6;
  localparam int LAG = 3;
  localparam logic [7:0] REF = 8'hA5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    settle_len = 8'd4;
  logic [7:0]    ref_byte = REF;
  logic [N*8-1:0] cap_bytes;
  logic [N*TW-1:0] tap_val;
  logic [N-1:0]  tap_load;
  logic          busy, done;
  logic [N-1:0]  timeout_err, sat_err;

  always #4 clk = ~clk;

  tap_skew_cal u_tap_skew_cal (
    .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
    .ref_byte(ref_byte), .cap_bytes(cap_bytes), .tap_val(tap_val),
    .tap_load(tap_load), .busy(busy), .done(done),
    .timeout_err(timeout_err), .sat_err(sat_err)
  );

  // delay-line model: lagged tap, failing threshold, optional marginal band
  int       thr [N];
  bit       marg = 1'b0;
  bit       ph = 1'b0;
  logic [TW-1:0] pipe [N][LAG];
  int       load_cnt = 0;

  always @(negedge clk) begin
    ph <= ~ph;
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < LAG; k++) begin
        if (rst)         pipe[c][k] <= '0;
        else if (k == 0) pipe[c][0] <= tap_val[c*TW +: TW];
        else             pipe[c][k] <= pipe[c][k-1];
      end
    end
    if (!rst && $countones(tap_load) == 1) load_cnt <= load_cnt + 1;
  end

  always_comb begin
    for (int c = 0; c < N; c++) begin
      int e;
      bit b;
      e = int'(pipe[c][LAG-1]);
      b = (e >= thr[c]) || (marg && (e + 2 >= thr[c]) && ph);
      cap_bytes[c*8 +: 8] = b ? ~REF : REF;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int            tap [N];
    logic [N-1:0]  tmo;
    logic [N-1:0]  sat;
    int            loads;
    int            base;
  } exp_t;

  exp_t sb_q [$];

  // monitor: pops one expectation per completed run
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (sb_q.size() == 0) begin
        chk("R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        for (int c = 0; c < N; c++)
          chk("R7", $sformatf("final tap lane %0d", c), int'(tap_val[c*TW +: TW]), e.tap[c]);
        chk("R6", "timeout_err", int'(timeout_err), int'(e.tmo));
        chk("R8", "sat_err", int'(sat_err), int'(e.sat));
        chk("R3", "sweep loads", load_cnt - e.base, e.loads);
        chk("R9", "all lanes loaded", int'(tap_load), (1 << N) - 1);
        chk("R9", "busy low at done", int'(busy), 0);
      end
    end
  end

  task automatic run_case(int t0, int t1, int t2, int t3, bit mg, bit restart);
    exp_t e;
    int rec [N];
    int mn;
    thr[0] = t0; thr[1] = t1; thr[2] = t2; thr[3] = t3;
    marg = mg;
    mn = 99;
    e.loads = 0;
    e.tmo = '0;
    e.sat = '0;
    for (int c = 0; c < N; c++) begin
      rec[c] = (thr[c] > 63) ? 63 : thr[c];
      e.tmo[c] = (thr[c] > 63);
      e.loads += rec[c] + 1;
      if (rec[c] < mn) mn = rec[c];
    end
    for (int c = 0; c < N; c++) begin
      int f;
      f = rec[c] - mn + 5 + 5 * c;
      e.sat[c] = (f > 63);
      e.tap[c] = (f > 63) ? 63 : f;
    end
    @(negedge clk);
    e.base = load_cnt;
    sb_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "done cleared", int'(done), 0);
    chk("R2", "errors cleared", int'({timeout_err, sat_err}), 0);
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2", "busy kept on restart pulse", int'(busy), 1);
    end
    @(posedge done);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < N; c++) thr[c] = 100;
    repeat (3) @(negedge clk);
    chk("R1", "tap_val in reset", int'(tap_val), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "tap_val", int'(tap_val), 0);
    chk("R1", "tap_load", int'(tap_load), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "errors", int'({timeout_err, sat_err}), 0);

    run_case(20, 23, 18, 30, 1'b0, 1'b0);   // R7 spread skew, R4 lag
    run_case(10, 10, 10, 10, 1'b1, 1'b0);   // R5 marginal band
    run_case(40, 40, 70, 40, 1'b0, 1'b0);   // R6 timeout
    run_case(0, 60, 10, 50, 1'b1, 1'b0);    // R8 clamp, zero threshold
    run_case(63, 12, 33, 12, 1'b0, 1'b1);   // R6 fail at 63, R2 restart ignored

    chk("R9", "scoreboard drained", sb_q.size(), 0);
    chk("R9", "done held", int'(done), 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule